// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank State Tracking

This block sits behind the registered command pins of a double-data-rate SDRAM model or a memory-controller monitor. Each clock it takes the chip select, row strobe, column strobe and write enable, the clock enable in this and the previous cycle, the two bank-select bits and address bit 10. It turns them into exactly one decoded command. The command covers the clock-enable transitions that enter and leave power-down and self refresh.

The block keeps an idle/active flag for each of four banks. It judges every command against that state and against the low-power state. A command that the state forbids raises a one-cycle illegal strobe and a sticky error flag, and it changes no state. All outputs are registered and show the command sampled at a clock edge right after that edge. Timing-parameter checks and the data path are not part of this block.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: Every output is a register that shows the command sampled at a rising edge right after that edge. `cmd_oh` is one-hot with these bit positions: 0 deselect, 1 no-op, 2 activate, 3 precharge one bank, 4 precharge all, 5 read, 6 write, 7 mode-register set, 8 auto refresh, 9 burst stop, 10 self-refresh entry, 11 power-down entry, 12 low-power exit. Synchronous reset gives `cmd_oh` = no-op, all banks idle, all flags low.
- R2: With `cs_n` high the command is deselect, whatever the other pins carry.
- R3: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decode as follows: 011 activate, 010 precharge, 100 write, 101 read, 000 mode-register set, 001 auto refresh, 111 no-op, 110 burst stop. `cmd_bank` carries `bank_sel`.
- R4: A precharge with `a10` high closes every bank (precharge all). With `a10` low it closes only the bank in `bank_sel`.
- R5: A read or write with `a10` high raises `auto_pre`. When the command is legal, the addressed bank is idle from that edge on.
- R6: On a mode-register set, `emr_sel` equals `bank_sel[0]`: 0 selects the mode register and 1 the extended one. `emr_sel` is low for every other command.
- R7: Activate is legal only when the addressed bank is idle, and it makes that bank active. Read and write need the addressed bank active. Burst stop needs at least one bank active.
- R8: Mode-register set and auto refresh are legal only when all banks are idle.
- R9: An illegal command pulses `illegal` for one cycle and sets `err`, which stays high until reset. The bank state and the low-power state do not change.
- R10: `cke` high in the previous cycle and low now, together with the auto-refresh encoding, enters self refresh (`sref`). This is legal only when all banks are idle.
- R11: `cke` falling together with no-op or deselect enters power-down: `pd_pre` if all banks are idle, `pd_act` if any bank is active.
- R12: In a low-power state, `cke` high with no-op or deselect is a low-power exit that clears `pd_pre`, `pd_act` and `sref`. `cke` high with any other command is illegal.
- R13: In a low-power state with `cke` low, the command pins are ignored: the command reads as no-op and no bank changes.
- R14: Outside a low-power state, `cke` falling with any command other than no-op, deselect or auto refresh is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as sampled this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | BANK_W | Addressed bank |
| a10 | input | 1 | Address bit 10 (all-banks / auto-precharge) |
| cmd_oh | output | 13 | One-hot decoded command |
| cmd_bank | output | BANK_W | Bank of the decoded command |
| auto_pre | output | 1 | Read or write with auto precharge |
| emr_sel | output | 1 | Mode-register set targets the extended register |
| illegal | output | 1 | Command was illegal for the current state |
| err | output | 1 | Sticky illegal-command flag |
| bank_active | output | 2**BANK_W | Per-bank active flag |
| pd_pre | output | 1 | In precharge power-down |
| pd_act | output | 1 | In active power-down |
| sref | output | 1 | In self refresh |

## Verification
The bench runs all 32 pin/`a10` patterns on every bank, repeated so that each pattern meets idle banks, active banks and mixed states. It then repeats the sweep with `cke` toggling, which drives entries into and exits from power-down and self refresh. The sweeps cover the following faults:
- A design that let a stale bank flag through would accept a second activate or reject a read.
- A design that ignored `a10` on precharge would leave other banks open.
- A design that sampled the pins during a low-power state would open banks while the clock was gated.
- Treating an illegal command as legal would shift the bank state and the following vectors would miscompare.
- Choosing active versus precharge power-down from the wrong state would swap `pd_act` and `pd_pre`.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int NUM_CMD = 13;

  typedef enum logic [3:0] {
    C_DESEL = 4'd0,
    C_NOP   = 4'd1,
    C_ACT   = 4'd2,
    C_PRE   = 4'd3,
    C_PREA  = 4'd4,
    C_RD    = 4'd5,
    C_WR    = 4'd6,
    C_MRS   = 4'd7,
    C_REF   = 4'd8,
    C_BST   = 4'd9,
    C_SRE   = 4'd10,
    C_PDE   = 4'd11,
    C_PDX   = 4'd12
  } cmd_e;
endpackage

// File: rtl/sdc_pin_decode.sv
module sdc_pin_decode
  import sdc_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e base_cmd
);
  always_comb begin
    if (cs_n) begin
      base_cmd = C_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  base_cmd = C_ACT;
        3'b010:  base_cmd = a10 ? C_PREA : C_PRE;
        3'b100:  base_cmd = C_WR;
        3'b101:  base_cmd = C_RD;
        3'b000:  base_cmd = C_MRS;
        3'b001:  base_cmd = C_REF;
        3'b110:  base_cmd = C_BST;
        default: base_cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdc_cke_stage.sv
module sdc_cke_stage
  import sdc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  cmd_e base_cmd,
  input  logic any_active,
  input  logic commit,
  output cmd_e eff_cmd,
  output logic cke_bad,
  output logic pd_pre,
  output logic pd_act,
  output logic sref
);
  logic cke_q;
  logic low_pwr;
  logic quiet;

  assign low_pwr = pd_pre | pd_act | sref;
  assign quiet   = (base_cmd == C_NOP) || (base_cmd == C_DESEL);

  // Clock-enable classification happens before the state legality check.
  always_comb begin
    eff_cmd = base_cmd;
    cke_bad = 1'b0;
    if (low_pwr) begin
      if (!cke)       eff_cmd = C_NOP;
      else if (quiet) eff_cmd = C_PDX;
      else            cke_bad = 1'b1;
    end else if (cke_q && !cke) begin
      if (base_cmd == C_REF) eff_cmd = C_SRE;
      else if (quiet)        eff_cmd = C_PDE;
      else                   cke_bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b0;
      pd_pre <= 1'b0;
      pd_act <= 1'b0;
      sref   <= 1'b0;
    end else begin
      cke_q <= cke;
      if (commit) begin
        case (eff_cmd)
          C_SRE: sref <= 1'b1;
          C_PDE: begin
            if (any_active) pd_act <= 1'b1;
            else            pd_pre <= 1'b1;
          end
          C_PDX: begin
            pd_pre <= 1'b0;
            pd_act <= 1'b0;
            sref   <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdc_bank_state.sv
module sdc_bank_state
  import sdc_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cmd_e                 eff_cmd,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 a10,
  input  logic                 commit,
  output logic [NUM_BANKS-1:0] active
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        active[g] <= 1'b0;
      end else if (commit) begin
        case (eff_cmd)
          C_ACT:       if (hit) active[g] <= 1'b1;
          C_PRE:       if (hit) active[g] <= 1'b0;
          C_PREA:      active[g] <= 1'b0;
          C_RD, C_WR:  if (hit && a10) active[g] <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdc_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_W-1:0]    bank_sel,
  input  logic                 a10,
  output logic [NUM_CMD-1:0]   cmd_oh,
  output logic [BANK_W-1:0]    cmd_bank,
  output logic                 auto_pre,
  output logic                 emr_sel,
  output logic                 illegal,
  output logic                 err,
  output logic [NUM_BANKS-1:0] bank_active,
  output logic                 pd_pre,
  output logic                 pd_act,
  output logic                 sref
);
  cmd_e base_cmd;
  cmd_e eff_cmd;
  logic cke_bad;
  logic ok;
  logic any_active;

  assign any_active = |bank_active;

  sdc_pin_decode i_pins (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (a10),
    .base_cmd (base_cmd)
  );

  sdc_cke_stage i_cke (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke),
    .base_cmd   (base_cmd),
    .any_active (any_active),
    .commit     (ok),
    .eff_cmd    (eff_cmd),
    .cke_bad    (cke_bad),
    .pd_pre     (pd_pre),
    .pd_act     (pd_act),
    .sref       (sref)
  );

  sdc_bank_state #(.BANK_W(BANK_W)) i_banks (
    .clk     (clk),
    .rst     (rst),
    .eff_cmd (eff_cmd),
    .bank    (bank_sel),
    .a10     (a10),
    .commit  (ok),
    .active  (bank_active)
  );

  // Legality against the bank state held before this edge.
  always_comb begin
    ok = !cke_bad;
    case (eff_cmd)
      C_ACT:               ok = ok && !bank_active[bank_sel];
      C_RD, C_WR:          ok = ok && bank_active[bank_sel];
      C_BST:               ok = ok && any_active;
      C_MRS, C_REF, C_SRE: ok = ok && !any_active;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_oh   <= NUM_CMD'(1) << C_NOP;
      cmd_bank <= '0;
      auto_pre <= 1'b0;
      emr_sel  <= 1'b0;
      illegal  <= 1'b0;
      err      <= 1'b0;
    end else begin
      cmd_oh   <= NUM_CMD'(1) << eff_cmd;
      cmd_bank <= bank_sel;
      auto_pre <= ((eff_cmd == C_RD) || (eff_cmd == C_WR)) && a10;
      emr_sel  <= (eff_cmd == C_MRS) && bank_sel[0];
      illegal  <= !ok;
      if (!ok) err <= 1'b1;
    end
  end
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
  import sdc_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_CMD-1:0]   cmd_oh,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic                 illegal,
  input logic                 err,
  input logic [NUM_BANKS-1:0] bank_active,
  input logic                 pd_pre,
  input logic                 pd_act,
  input logic                 sref
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst) $onehot(cmd_oh));
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst) err |=> err);
  p_flag_err_r9: assert property (@(posedge clk) disable iff (rst) illegal |-> err);
  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($stable(bank_active) && $stable({pd_pre, pd_act, sref})));
  p_one_mode_r11: assert property (@(posedge clk) disable iff (rst) $onehot0({pd_pre, pd_act, sref}));
  p_pdpre_idle_r11: assert property (@(posedge clk) disable iff (rst) pd_pre |-> (bank_active == '0));
  p_sref_idle_r10: assert property (@(posedge clk) disable iff (rst) sref |-> (bank_active == '0));
  p_act_opens_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_oh[C_ACT] && !illegal) |-> bank_active[cmd_bank]);
  p_mrs_idle_r8: assert property (@(posedge clk) disable iff (rst)
    ((cmd_oh[C_MRS] || cmd_oh[C_REF]) && !illegal) |-> (bank_active == '0));
  p_exit_r12: assert property (@(posedge clk) disable iff (rst)
    (cmd_oh[C_PDX] && !illegal) |-> !(pd_pre || pd_act || sref));
endmodule

bind sdram_cmd_decoder sdc_checker #(.BANK_W(BANK_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_oh      (cmd_oh),
  .cmd_bank    (cmd_bank),
  .illegal     (illegal),
  .err         (err),
  .bank_active (bank_active),
  .pd_pre      (pd_pre),
  .pd_act      (pd_act),
  .sref        (sref)
);

// File: tb/test_sdram_cmd_decoder.sv
module test_sdram_cmd_decoder;
  import sdc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 2;
  localparam int NB = 1 << BW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [BW-1:0] bank_sel = '0;
  logic [NUM_CMD-1:0] cmd_oh;
  logic [BW-1:0] cmd_bank;
  logic auto_pre, emr_sel, illegal, err, pd_pre, pd_act, sref;
  logic [NB-1:0] bank_active;

  int vectors = 0;
  int fails = 0;

  // Reference state derived from the requirements.
  logic [NB-1:0] m_act = '0;
  logic m_err = 0, m_pdp = 0, m_pda = 0, m_sr = 0, m_ckeq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_decoder #(.BANK_W(BW)) i_sdram_cmd_decoder (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank_sel(bank_sel), .a10(a10), .cmd_oh(cmd_oh),
    .cmd_bank(cmd_bank), .auto_pre(auto_pre), .emr_sel(emr_sel),
    .illegal(illegal), .err(err), .bank_active(bank_active),
    .pd_pre(pd_pre), .pd_act(pd_act), .sref(sref)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic cmd_e ref_pins(input logic c, r, ca, w, a);
    if (c) return C_DESEL;
    case ({r, ca, w})
      3'b011: return C_ACT;
      3'b010: return a ? C_PREA : C_PRE;
      3'b100: return C_WR;
      3'b101: return C_RD;
      3'b000: return C_MRS;
      3'b001: return C_REF;
      3'b110: return C_BST;
      default: return C_NOP;
    endcase
  endfunction

  task automatic apply(input logic c, r, ca, w, k, input logic [BW-1:0] b, input logic a);
    cmd_e base, eff;
    logic bad, good, lp, quiet, exp_ap, exp_emr;
    base  = ref_pins(c, r, ca, w, a);
    quiet = (base == C_NOP) || (base == C_DESEL);
    lp    = m_pdp | m_pda | m_sr;
    eff   = base;
    bad   = 1'b0;
    if (lp) begin                        // R12, R13
      if (!k) eff = C_NOP;
      else if (quiet) eff = C_PDX;
      else bad = 1'b1;
    end else if (m_ckeq && !k) begin     // R10, R11, R14
      if (base == C_REF) eff = C_SRE;
      else if (quiet) eff = C_PDE;
      else bad = 1'b1;
    end
    good = !bad;
    case (eff)
      C_ACT:               good = good && !m_act[b];
      C_RD, C_WR:          good = good && m_act[b];
      C_BST:               good = good && (m_act != '0);
      C_MRS, C_REF, C_SRE: good = good && (m_act == '0);
      default: ;
    endcase
    exp_ap  = ((eff == C_RD) || (eff == C_WR)) && a;
    exp_emr = (eff == C_MRS) && b[0];
    if (good) begin
      case (eff)
        C_ACT:  m_act[b] = 1'b1;
        C_PRE:  m_act[b] = 1'b0;
        C_PREA: m_act = '0;
        C_RD, C_WR: if (a) m_act[b] = 1'b0;
        C_SRE:  m_sr = 1'b1;
        C_PDE:  if (m_act != '0) m_pda = 1'b1; else m_pdp = 1'b1;
        C_PDX:  begin m_pdp = 0; m_pda = 0; m_sr = 0; end
        default: ;
      endcase
    end else begin
      m_err = 1'b1;
    end
    m_ckeq = k;

    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; bank_sel = b; a10 = a;
    @(posedge clk);
    #1;
    chk("R3", "cmd_oh", 16'(cmd_oh), 16'(NUM_CMD'(1) << eff));
    chk("R3", "cmd_bank", 16'(cmd_bank), 16'(b));
    chk("R5", "auto_pre", 16'(auto_pre), 16'(exp_ap));
    chk("R6", "emr_sel", 16'(emr_sel), 16'(exp_emr));
    chk("R9", "illegal", 16'(illegal), 16'(!good));
    chk("R9", "err", 16'(err), 16'(m_err));
    chk("R7", "bank_active", 16'(bank_active), 16'(m_act));
    chk("R11", "power state", 16'({pd_pre, pd_act, sref}), 16'({m_pdp, m_pda, m_sr}));
  endtask

  task automatic apply_code(input logic [4:0] code, input logic k, input logic [BW-1:0] b);
    apply(code[4], code[3], code[2], code[1], k, b, code[0]);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1", "reset cmd_oh", 16'(cmd_oh), 16'(NUM_CMD'(1) << C_NOP));
    chk("R1", "reset banks", 16'(bank_active), 16'h0);
    chk("R1", "reset err", 16'(err), 16'h0);
    @(negedge clk);
    rst = 1'b0;

    // R2, R3, R4, R5, R7, R8: every pin/a10 pattern on every bank, clock enabled
    for (int pass = 0; pass < 3; pass++)
      for (int code = 0; code < 32; code++)
        for (int b = 0; b < NB; b++)
          apply_code(5'(code ^ (pass * 7)), 1'b1, BW'(b + pass));

    // R6: mode-register select from an all-idle state
    apply(0, 0, 1, 0, 1, 2'd0, 1);         // precharge all
    apply(0, 0, 0, 0, 1, 2'd0, 0);         // mode register
    apply(0, 0, 0, 0, 1, 2'd1, 0);         // extended mode register
    apply(0, 0, 0, 0, 1, 2'd3, 1);

    // R11, R13, R12: precharge power-down, ignored pins, illegal wake, exit
    apply(0, 1, 1, 1, 0, 2'd0, 0);         // cke falls with NOP
    apply(0, 0, 1, 1, 0, 2'd2, 0);         // activate ignored while cke low
    apply(0, 0, 1, 1, 1, 2'd2, 0);         // cke high with activate: illegal
    apply(1, 0, 0, 0, 1, 2'd0, 0);         // exit with deselect
    // R11: active power-down
    apply(0, 0, 1, 1, 1, 2'd2, 0);
    apply(1, 1, 1, 1, 0, 2'd1, 0);
    apply(1, 1, 1, 1, 0, 2'd1, 0);
    apply(0, 1, 1, 1, 1, 2'd1, 0);
    // R10: self refresh refused with an open bank, then taken when idle
    apply(0, 0, 0, 1, 0, 2'd0, 0);
    apply(0, 1, 1, 1, 1, 2'd0, 0);
    apply(0, 0, 1, 0, 1, 2'd0, 1);
    apply(0, 0, 0, 1, 0, 2'd0, 0);
    apply(0, 1, 0, 1, 0, 2'd0, 0);
    apply(0, 1, 1, 1, 1, 2'd0, 0);
    // R14: cke falling with a read
    apply(0, 0, 1, 1, 1, 2'd3, 0);
    apply(0, 1, 0, 1, 0, 2'd3, 0);
    apply(0, 1, 1, 1, 1, 2'd3, 0);

    // Clock-enable sweep: every pattern under both cke levels
    for (int code = 0; code < 32; code++)
      for (int k = 0; k < 4; k++)
        apply_code(5'(code), k[0] ^ k[1], BW'(code + k));
    apply(0, 1, 1, 1, 1, 2'd0, 0);
    apply(0, 1, 1, 1, 1, 2'd0, 0);

    summary();
    $finish;
  end
endmodule